// File: doc/BRIEF.md
# Length-Prefixed Packet FIFO

This block buffers variable-length packets in a byte-wide queue of fixed depth. Each stored packet begins with a length byte that gives only the number of payload bytes that follow it. A producer asks to enqueue a packet by presenting its payload length. The block admits the packet only as a whole. It rejects the request if the packet plus its length byte could never fit in the queue, or if it does not fit in the space currently free. Once the block has admitted a packet, it writes the length byte at once and then takes the payload bytes one by one on a write strobe.

On the consumer side the block looks at the byte at the head of the queue. It raises a packet-ready flag once the stored byte count covers that head byte and the payload it announces. A read transaction, started by a one-cycle request, pops the length byte and then exactly that many payload bytes, one per cycle. Payload bytes whose position lies at or beyond a consumer-supplied limit are still removed from the queue, but they are not marked valid at the output. A count output always reports how many bytes are stored.

Top module: `lenpkt_fifo`

## Requirements
- R1: After reset, `occupancy` is 0, and `pkt_ready`, `enq_ack`, `enq_nak`, `enq_busy`, `out_valid` and `out_last` are all 0.
- R2: An enqueue request whose payload length plus one exceeds DEPTH (128) gets `enq_nak` in the cycle after the request. Nothing is written and `occupancy` does not change.
- R3: An enqueue request whose payload length plus one exceeds DEPTH minus `occupancy` gets `enq_nak`, and `occupancy` does not change.
- R4: An admitted request gets `enq_ack` in the cycle after the request, and the length byte is stored in the same edge. After that, each cycle with `wr_valid` high stores one payload byte until the announced count is reached, so `occupancy` grows by the length plus one. `enq_ack` and `enq_nak` are never high together.
- R5: A request with payload length 0 stores only its length byte. It is admitted whenever at least one byte is free.
- R6: `pkt_ready` is 0 while the queue is empty, and 0 while the stored count is below the head byte value plus one (a packet whose payload is still being written). It rises once the whole packet is stored.
- R7: A read transaction outputs the length byte first, with `out_valid` high one cycle after the accepted `rd_start`. It then outputs the payload bytes in write order, one per cycle. `out_last` is high with the final byte of the packet, and `occupancy` drops by the length plus one.
- R8: A payload byte at index j (counting from 0) is output with `out_valid` high only if j < `rd_limit`, sampled at `rd_start`. Bytes at or beyond the limit are popped with `out_valid` low.
- R9: In a cycle in which one byte is pushed and one byte is popped, `occupancy` is unchanged.
- R10: An enqueue request made while an earlier admitted packet is still taking payload (`enq_busy` high) gets `enq_nak`.
- R11: `rd_start` while `pkt_ready` is 0 has no effect: no output byte appears and `occupancy` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_req | input | 1 | One-cycle request to admit a packet |
| enq_len | input | 8 | Payload length of the requested packet |
| wr_valid | input | 1 | Payload byte strobe during the fill phase |
| wr_data | input | 8 | Payload byte |
| enq_ack | output | 1 | Request admitted (one-cycle pulse) |
| enq_nak | output | 1 | Request rejected (one-cycle pulse) |
| enq_busy | output | 1 | Admitted packet still awaiting payload bytes |
| rd_start | input | 1 | One-cycle request to pop the head packet |
| rd_limit | input | 8 | Number of payload bytes the consumer keeps |
| pkt_ready | output | 1 | A complete packet sits at the head |
| out_valid | output | 1 | `out_data` carries a delivered byte |
| out_data | output | 8 | Popped byte |
| out_last | output | 1 | Final byte of the popped packet |
| occupancy | output | 8 | Bytes currently stored, 0 to 128 |

## Verification
The write side and the read side can touch the queue in the same cycle. A payload byte is being pushed for one packet while the bytes of an earlier packet are popped. A second enqueue request can also arrive during that overlap. The bench provokes this by starting a read of a stored packet while it streams payload for a newly admitted one. It judges the overlap by checking that the count holds still across the overlapping cycles, that the request arriving meanwhile is refused, and that both packets come out intact afterwards.

// File: rtl/lenpkt_pkg.sv
package lenpkt_pkg;
  typedef enum logic {ADM_IDLE, ADM_FILL} adm_state_e;
  typedef enum logic {DRN_IDLE, DRN_POP} drn_state_e;
endpackage

// File: rtl/lenpkt_store.sv
module lenpkt_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lenpkt_admit.sv
module lenpkt_admit
  import lenpkt_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = 7,
  parameter int OW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] occ,
  input  logic          enq_req,
  input  logic [DW-1:0] enq_len,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          enq_ack,
  output logic          enq_nak,
  output logic          busy
);
  adm_state_e    st;
  logic [AW-1:0] wr_ptr;
  logic [DW-1:0] rem;
  logic          fits_max, fits_free, accept;

  assign fits_max  = (int'(enq_len) + 1) <= DEPTH;
  assign fits_free = (int'(enq_len) + 1) <= (DEPTH - int'(occ));
  assign accept    = (st == ADM_IDLE) && enq_req && fits_max && fits_free;
  assign push      = accept || ((st == ADM_FILL) && wr_valid);
  assign wdata     = accept ? enq_len : wr_data;
  assign waddr     = wr_ptr;
  assign busy      = (st == ADM_FILL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ADM_IDLE;
      wr_ptr  <= '0;
      rem     <= '0;
      enq_ack <= 1'b0;
      enq_nak <= 1'b0;
    end else begin
      enq_ack <= accept;
      enq_nak <= enq_req && !accept;
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (accept) begin
        rem <= enq_len;
        st  <= (enq_len == '0) ? ADM_IDLE : ADM_FILL;
      end else if ((st == ADM_FILL) && wr_valid) begin
        rem <= rem - 1'b1;
        if (rem == DW'(1)) st <= ADM_IDLE;
      end
    end
  end

  AST_OVERSIZE_NAK: assert property (@(posedge clk) disable iff (rst)
    (enq_req && (int'(enq_len) >= DEPTH)) |=> (enq_nak && !enq_ack)); // R2
  AST_BUSY_NAK: assert property (@(posedge clk) disable iff (rst)
    (enq_req && busy) |=> (enq_nak && !enq_ack)); // R10
  AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(enq_ack && enq_nak)); // R4
endmodule

// File: rtl/lenpkt_drain.sv
module lenpkt_drain
  import lenpkt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] occ,
  input  logic [DW-1:0] head,
  input  logic          rd_start,
  input  logic [DW-1:0] rd_limit,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic          pkt_ready,
  output logic          out_valid,
  output logic          out_last
);
  drn_state_e    st;
  logic [AW-1:0] rd_ptr;
  logic [DW-1:0] cnt, idx, lim;
  logic          peek_vld, start;

  // head is trusted only when it was read from a stable, occupied pointer
  assign pkt_ready = (st == DRN_IDLE) && peek_vld && (int'(occ) >= int'(head) + 1);
  assign start     = (st == DRN_IDLE) && rd_start && pkt_ready;
  assign pop       = start || (st == DRN_POP);
  assign raddr     = rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= DRN_IDLE;
      rd_ptr    <= '0;
      cnt       <= '0;
      idx       <= '0;
      lim       <= '0;
      peek_vld  <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      peek_vld  <= !pop && (occ != '0);
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      if (start) begin
        out_valid <= 1'b1;
        out_last  <= (head == '0);
        cnt       <= head;
        idx       <= '0;
        lim       <= rd_limit;
        st        <= (head == '0) ? DRN_IDLE : DRN_POP;
      end else if (st == DRN_POP) begin
        out_valid <= (idx < lim);
        out_last  <= (cnt == DW'(1));
        cnt       <= cnt - 1'b1;
        idx       <= idx + 1'b1;
        if (cnt == DW'(1)) st <= DRN_IDLE;
      end
    end
  end

  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> !pkt_ready); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> (occ != '0)); // R7
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (rst)
    (rd_start && !pkt_ready && (st == DRN_IDLE)) |=> !out_valid); // R11
endmodule

// File: rtl/lenpkt_fifo.sv
module lenpkt_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq_req,
  input  logic [DW-1:0] enq_len,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          enq_ack,
  output logic          enq_nak,
  output logic          enq_busy,
  input  logic          rd_start,
  input  logic [DW-1:0] rd_limit,
  output logic          pkt_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic [$clog2(DEPTH):0] occupancy
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;

  logic          push, pop;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;

  lenpkt_admit #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .OW(OW)) u_admit (
    .clk(clk), .rst(rst), .occ(occupancy), .enq_req(enq_req), .enq_len(enq_len),
    .wr_valid(wr_valid), .wr_data(wr_data), .push(push), .waddr(waddr),
    .wdata(wdata), .enq_ack(enq_ack), .enq_nak(enq_nak), .busy(enq_busy)
  );

  lenpkt_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .we(push), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  lenpkt_drain #(.DW(DW), .AW(AW), .OW(OW)) u_drain (
    .clk(clk), .rst(rst), .occ(occupancy), .head(rdata), .rd_start(rd_start),
    .rd_limit(rd_limit), .pop(pop), .raddr(raddr), .pkt_ready(pkt_ready),
    .out_valid(out_valid), .out_last(out_last)
  );

  assign out_data = rdata;

  always_ff @(posedge clk) begin
    if (rst) occupancy <= '0;
    else begin
      case ({push, pop})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (int'(occupancy) < DEPTH)); // R3
  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(occupancy)); // R9
  AST_OCC_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= DEPTH); // R4
endmodule

// File: tb/lenpkt_fifo_bench.sv
module lenpkt_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam int V_LEN [NV] = '{3, 10, 0, 127, 128, 200, 1};
  localparam int V_LIM [NV] = '{8, 4, 5, 127, 0, 0, 0};
  localparam int V_ACK [NV] = '{1, 1, 1, 1, 0, 0, 1};

  logic       clk = 0, rst = 1;
  logic       enq_req = 0, wr_valid = 0, rd_start = 0;
  logic [7:0] enq_len = 0, wr_data = 0, rd_limit = 0;
  logic       enq_ack, enq_nak, enq_busy, pkt_ready, out_valid, out_last;
  logic [7:0] out_data, occupancy;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lenpkt_fifo u_lenpkt_fifo (
    .clk(clk), .rst(rst), .enq_req(enq_req), .enq_len(enq_len),
    .wr_valid(wr_valid), .wr_data(wr_data), .enq_ack(enq_ack), .enq_nak(enq_nak),
    .enq_busy(enq_busy), .rd_start(rd_start), .rd_limit(rd_limit),
    .pkt_ready(pkt_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .occupancy(occupancy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // request admission; returns after the response is visible
  task automatic enq_only(input int len, input bit exp_ack, input string tag);
    enq_req = 1; enq_len = 8'(len);
    @(negedge clk);
    enq_req = 0;
    chk(enq_ack == exp_ack && enq_nak == !exp_ack, tag, {enq_ack, enq_nak}, {exp_ack, !exp_ack});
  endtask

  task automatic put_bytes(input int base, input int from, input int n);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = 8'(base + from + i);
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic read_pkt(input int len, input int limit, input int base, input string tag);
    int w = 0, errs = 0, ev, ed, el;
    while (!pkt_ready && w < 4) begin @(negedge clk); w++; end
    chk(pkt_ready == 1, {tag, " ready"}, pkt_ready, 1);
    rd_limit = 8'(limit); rd_start = 1;
    @(negedge clk);
    rd_start = 0;
    for (int k = 0; k <= len; k++) begin
      if (k == 0) begin ev = 1; ed = len; end
      else begin ev = ((k - 1) < limit); ed = (base + k - 1) & 255; end
      el = (k == len);
      if (out_valid != ev || out_last != el || (ev && out_data != 8'(ed))) begin
        if (errs == 0)
          $display("FAIL %s byte %0d actual v=%0d d=%0d l=%0d expected v=%0d d=%0d l=%0d",
                   tag, k, out_valid, out_data, out_last, ev, ed, el);
        errs++;
      end
      if (k < len) @(negedge clk);
    end
    checks++;
    if (errs != 0) fails++;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(occupancy == 0 && !pkt_ready && !enq_ack && !enq_nak && !enq_busy && !out_valid && !out_last,
        "R1 reset", occupancy, 0);

    // R11 start on empty queue
    rd_start = 1; @(negedge clk); rd_start = 0; @(negedge clk);
    chk(!out_valid && occupancy == 0, "R11 empty start", out_valid, 0);

    // vector table: R2 R4 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      enq_only(V_LEN[i], V_ACK[i], V_ACK[i] ? "R4 admit" : "R2 oversize");
      if (V_ACK[i] != 0) begin
        put_bytes(i * 16 + 1, 0, V_LEN[i]);
        chk(occupancy == 8'(V_LEN[i] + 1), "R4 occupancy", occupancy, V_LEN[i] + 1);
        read_pkt(V_LEN[i], V_LIM[i], i * 16 + 1, "R7 R8 pop");
        @(negedge clk);
        chk(occupancy == 0, "R7 drained", occupancy, 0);
      end else begin
        chk(occupancy == 0, "R2 untouched", occupancy, 0);
      end
    end

    // R6 partial packet not ready; R11 start ignored meanwhile
    enq_only(5, 1, "R4 admit partial");
    put_bytes(8'h80, 0, 2);
    repeat (3) @(negedge clk);
    chk(!pkt_ready && occupancy == 3, "R6 partial", pkt_ready, 0);
    rd_start = 1; @(negedge clk); rd_start = 0; @(negedge clk);
    chk(!out_valid && occupancy == 3, "R11 partial start", occupancy, 3);
    put_bytes(8'h80, 2, 3);
    repeat (2) @(negedge clk);
    chk(pkt_ready == 1, "R6 complete", pkt_ready, 1);
    read_pkt(5, 255, 8'h80, "R7 partial pop");
    @(negedge clk);

    // R3 R5 free-space limits
    enq_only(100, 1, "R4 admit 100");
    put_bytes(8'h40, 0, 100);
    chk(occupancy == 101, "R4 occ 101", occupancy, 101);
    enq_only(30, 0, "R3 no room");
    chk(occupancy == 101, "R3 untouched", occupancy, 101);
    enq_only(26, 1, "R3 exact fit");
    put_bytes(8'hA0, 0, 26);
    chk(occupancy == 128, "R3 full", occupancy, 128);
    enq_only(0, 0, "R5 zero when full");
    read_pkt(100, 255, 8'h40, "R7 pop 100");
    @(negedge clk);
    enq_only(0, 1, "R5 zero admit");
    chk(occupancy == 28, "R5 occ", occupancy, 28);
    read_pkt(26, 255, 8'hA0, "R7 pop 26");
    @(negedge clk);
    read_pkt(0, 0, 0, "R5 pop zero");
    @(negedge clk);
    chk(occupancy == 0, "R5 drained", occupancy, 0);

    // R9 R10 push and pop in the same cycles
    enq_only(10, 1, "R4 admit A");
    put_bytes(8'h10, 0, 10);
    repeat (2) @(negedge clk);
    enq_only(20, 1, "R4 admit B");
    chk(occupancy == 12 && pkt_ready, "R9 before", occupancy, 12);
    rd_limit = 8'd255;
    for (int k = 0; k < 6; k++) begin
      wr_valid = 1; wr_data = 8'(8'h60 + k);
      rd_start = (k == 0);
      if (k == 2) begin enq_req = 1; enq_len = 8'd3; end
      @(negedge clk);
      enq_req = 0;
      if (k == 2) chk(enq_nak && !enq_ack, "R10 busy nak", enq_nak, 1);
    end
    wr_valid = 0; rd_start = 0;
    chk(occupancy == 12, "R9 held", occupancy, 12);
    repeat (6) @(negedge clk);
    chk(occupancy == 7, "R9 after", occupancy, 7);
    put_bytes(8'h60, 6, 14);
    chk(occupancy == 21, "R4 occ B", occupancy, 21);
    read_pkt(20, 255, 8'h60, "R9 pop B");
    @(negedge clk);
    chk(occupancy == 0, "R7 final", occupancy, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule